// File: doc/BRIEF.md
# Pin-Change GPIO Register Block

This block holds the configuration of an eight-pin general-purpose I/O port and reports pin activity to a host. The host reaches it over a simple parallel register bus. One address is shared by reads and writes, and each has its own strobe. The block drives an output-enable vector and an output-level vector toward the pads. It samples the pad inputs through a synchronizer and pulls an active-low interrupt line when an enabled input pin changes level.

Three registers hold the configuration: pin direction, per-pin interrupt enable, and a control byte. The control byte carries a self-clearing soft-reset bit and a bit that freezes the reported pin levels at the moment an interrupt is raised. Two actions clear a pending interrupt: a write to the direction register, or a read of the pin-level register. Pins set as outputs drive a low level, and pins set as inputs are left undriven. This gives open-drain behaviour at the pad.

Top module: `gpx_port_ctrl`

## Requirements
- R1: Writing the direction register at address 0x0A sets `pin_oe` to the written byte at the next clock edge. Bit n of the byte is pin n, 1 means output and 0 means input. A read returns the stored byte.
- R2: A read of address 0x0B returns the pin levels after a two-flop synchronizer. A write to 0x0B changes no register and no output.
- R3: The interrupt-enable register lives at address 0x0C. A level change on pin n raises the pending interrupt only if pin n is an input and its enable bit is 1. `irq_n` goes low at the third clock edge after the new pin level is applied.
- R4: The control register lives at address 0x0E. Bit 0 enables input latching, and bit 3 requests a soft reset. All other bits ignore writes and read as 0.
- R5: Any write to the direction register clears a pending interrupt, and `irq_n` is high after that edge.
- R6: Reads of addresses 0x00–0x09, 0x0D, 0x0F and above return 0. Writes to those addresses have no effect.
- R7: Writing 1 to control bit 3 sets that bit for one cycle. At the following edge every register returns to 0: all pins become inputs, all enables are clear, latching is off and `irq_n` is high.
- R8: A read of address 0x0B clears a pending interrupt, and `irq_n` is high after that edge.
- R9: While latching is enabled, the pin levels seen when an interrupt is raised are held. Reads of 0x0B return those held levels until the first such read. Later changes do not overwrite them. After that read, reads of 0x0B again return live levels.
- R10: `rd_data` updates at the clock edge that samples `rd_en`, and it holds its value while `rd_en` is low.
- R11: `pin_out` is 0 on every pin at all times, so output pins drive low.
- R12: A synchronous active-high `rst` clears all registers: `pin_oe` is 0, `irq_n` is 1 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 8 | Register address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| pin_in | input | 8 | Pad input levels |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output level |
| irq_n | output | 1 | Interrupt, active low |

## Verification
Register writes show on `pin_oe` one edge after the write strobe is sampled, and read data is valid one edge after `rd_en`. Clearing `irq_n` by a direction write or a state read also takes one edge. A pin change reaches `irq_n` at the third edge, because it passes two synchronizer flops and then the pending flop. A soft reset takes two edges: one to set the request bit and one to reset the block. The bench drives inputs on falling edges and samples on the falling edge after the edge where each result is due. Read results go through a queue that is popped one cycle after each read strobe. Interrupt timing is checked both one edge before and at the edge where `irq_n` falls.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam logic [7:0] A_DIR   = 8'h0A;
  localparam logic [7:0] A_STATE = 8'h0B;
  localparam logic [7:0] A_IEN   = 8'h0C;
  localparam logic [7:0] A_CTL   = 8'h0E;
  localparam int unsigned CTL_LATCH_BIT = 0;
  localparam int unsigned CTL_SRST_BIT  = 3;

  function automatic logic is_mapped(input logic [7:0] a);
    return (a == A_DIR) || (a == A_STATE) || (a == A_IEN) || (a == A_CTL);
  endfunction
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk) begin
    if (rst) st[0] <= '0;
    else     st[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[i] <= '0;
      else     st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/gpx_cfg_regs.sv
module gpx_cfg_regs
  import gpx_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [N-1:0]  wr_data,
  output logic [N-1:0]  dir_q,
  output logic [N-1:0]  ien_q,
  output logic          latch_q,
  output logic          srst_q,
  output logic          dir_wr
);
  logic [7:0] a8;
  assign a8     = 8'(addr);
  assign dir_wr = wr_en && (a8 == A_DIR);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= '0;
      ien_q   <= '0;
      latch_q <= 1'b0;
      srst_q  <= 1'b0;
    end else begin
      srst_q <= 1'b0;
      if (wr_en) begin
        case (a8)
          A_DIR: dir_q <= wr_data;
          A_IEN: ien_q <= wr_data;
          A_CTL: begin
            latch_q <= wr_data[CTL_LATCH_BIT];
            srst_q  <= wr_data[CTL_SRST_BIT];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpx_event.sv
module gpx_event #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pins_s,
  input  logic [N-1:0] dir,
  input  logic [N-1:0] ien,
  input  logic         latch_en,
  input  logic         dir_wr,
  input  logic         rd_state,
  output logic         pend_q,
  output logic [N-1:0] snap_q,
  output logic         snap_vld_q
);
  logic [N-1:0] prev_q;
  logic [N-1:0] chg;
  logic         set_ev;
  logic         clr_ev;

  assign chg    = (pins_s ^ prev_q) & ien & ~dir;
  assign set_ev = |chg;
  assign clr_ev = dir_wr || rd_state;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q     <= '0;
      pend_q     <= 1'b0;
      snap_q     <= '0;
      snap_vld_q <= 1'b0;
    end else begin
      prev_q <= pins_s;
      if (clr_ev)      pend_q <= 1'b0;
      else if (set_ev) pend_q <= 1'b1;
      if (!latch_en || rd_state) begin
        snap_vld_q <= 1'b0;
      end else if (set_ev && !snap_vld_q) begin
        snap_q     <= pins_s;
        snap_vld_q <= 1'b1;
      end
    end
  end

  assert_dirwr_clears_R5: assert property (@(posedge clk) disable iff (rst)
    dir_wr |=> !pend_q);
  assert_pend_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> $past(|((pins_s ^ prev_q) & ien & ~dir)));
  assert_snap_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (snap_vld_q && latch_en && !rd_state) |=> $stable(snap_q));
endmodule

// File: rtl/gpx_port_ctrl.sv
module gpx_port_ctrl
  import gpx_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned N_PINS      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [N_PINS-1:0] wr_data,
  input  logic              rd_en,
  output logic [N_PINS-1:0] rd_data,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_oe,
  output logic [N_PINS-1:0] pin_out,
  output logic              irq_n
);
  logic [N_PINS-1:0] pins_s, dir_q, ien_q, snap_q, ctl_rb, rd_nxt;
  logic latch_q, srst_q, dir_wr, pend_q, snap_vld_q, rst_all, rd_state;
  logic [7:0] a8;

  assign a8       = 8'(addr);
  assign rst_all  = rst || srst_q;
  assign rd_state = rd_en && (a8 == A_STATE);

  gpx_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst_all), .d(pin_in), .q(pins_s));

  gpx_cfg_regs #(.N(N_PINS), .AW(ADDR_W)) u_cfg (
    .clk(clk), .rst(rst_all), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .dir_q(dir_q), .ien_q(ien_q), .latch_q(latch_q), .srst_q(srst_q),
    .dir_wr(dir_wr));

  gpx_event #(.N(N_PINS)) u_evt (
    .clk(clk), .rst(rst_all), .pins_s(pins_s), .dir(dir_q), .ien(ien_q),
    .latch_en(latch_q), .dir_wr(dir_wr), .rd_state(rd_state),
    .pend_q(pend_q), .snap_q(snap_q), .snap_vld_q(snap_vld_q));

  always_comb begin
    ctl_rb = '0;
    ctl_rb[CTL_LATCH_BIT] = latch_q;
    ctl_rb[CTL_SRST_BIT]  = srst_q;
    case (a8)
      A_DIR:   rd_nxt = dir_q;
      A_STATE: rd_nxt = snap_vld_q ? snap_q : pins_s;
      A_IEN:   rd_nxt = ien_q;
      A_CTL:   rd_nxt = ctl_rb;
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst_all)    rd_data <= '0;
    else if (rd_en) rd_data <= rd_nxt;
  end

  assign pin_oe  = dir_q;
  assign pin_out = '0;
  assign irq_n   = ~pend_q;

  assert_dir_write_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && a8 == A_DIR && !srst_q) |=> (pin_oe == $past(wr_data)));
  assert_state_wr_noeff_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && a8 == A_STATE && !srst_q) |=> (pin_oe == $past(pin_oe)));
  assert_resv_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !is_mapped(a8)) |=> (rd_data == '0));
  assert_srst_done_R7: assert property (@(posedge clk) disable iff (rst)
    srst_q |=> (!srst_q && pin_oe == '0 && irq_n));
  assert_state_rd_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_state && !srst_q) |=> irq_n);
  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !srst_q) |=> $stable(rd_data));
  assert_out_low_R11: assert property (@(posedge clk) pin_out == '0);
endmodule

// File: tb/sim_gpx_port_ctrl.sv
module sim_gpx_port_ctrl;
  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0, wr_data = '0, pin_in = '0;
  logic [7:0] rd_data, pin_oe, pin_out;
  logic irq_n;
  int n_run = 0, n_fail = 0;
  logic rd_seen = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic done = 1'b0;

  always #2 clk = ~clk;

  gpx_port_ctrl u0 (.clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out), .irq_n(irq_n));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= rd_en;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("R10 unexpected read", 8'h00, 8'hFF);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    check("watchdog", 8'h00, 8'h01);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v1;
    idle(3);
    rst = 1'b0;
    check("R12 oe after reset", pin_oe, 8'h00);
    check("R12 irq after reset", {7'b0, irq_n}, 8'h01);
    check("R12 rd_data after reset", rd_data, 8'h00);
    check("R11 out low", pin_out, 8'h00);

    wr(8'h0A, 8'hF0);
    check("R1 oe after dir write", pin_oe, 8'hF0);
    rd(8'h0A, 8'hF0, "R1 dir readback");

    pin_in = 8'h5A; idle(3);
    rd(8'h0B, 8'h5A, "R2 live pins");
    wr(8'h0B, 8'hFF);
    rd(8'h0B, 8'h5A, "R2 state write ignored");
    rd(8'h0A, 8'hF0, "R2 dir unchanged after state write");
    idle(3);
    check("R10 rd_data holds", rd_data, 8'hF0);

    wr(8'h05, 8'hFF);
    rd(8'h05, 8'h00, "R6 reserved 0x05");
    rd(8'h0D, 8'h00, "R6 reserved 0x0D");
    rd(8'h0F, 8'h00, "R6 reserved 0x0F");
    rd(8'h0A, 8'hF0, "R6 dir unaffected");

    wr(8'h0E, 8'hF1);
    rd(8'h0E, 8'h01, "R4 control reserved bits");
    wr(8'h0E, 8'h00);
    rd(8'h0E, 8'h00, "R4 control cleared");

    wr(8'h0C, 8'h0F);
    rd(8'h0C, 8'h0F, "R3 enable readback");
    pin_in = pin_in ^ 8'h10; idle(5);
    check("R3 output pin no irq", {7'b0, irq_n}, 8'h01);
    pin_in = pin_in ^ 8'h01; idle(2);
    check("R3 irq not yet", {7'b0, irq_n}, 8'h01);
    idle(1);
    check("R3 irq at third edge", {7'b0, irq_n}, 8'h00);
    wr(8'h0A, 8'hF0);
    check("R5 dir write clears", {7'b0, irq_n}, 8'h01);

    wr(8'h0A, 8'h00);
    pin_in = pin_in ^ 8'h40; idle(5);
    check("R3 disabled pin no irq", {7'b0, irq_n}, 8'h01);

    pin_in = pin_in ^ 8'h02; idle(4);
    check("R8 irq before read", {7'b0, irq_n}, 8'h00);
    rd(8'h0B, pin_in, "R8 state read data");
    check("R8 state read clears", {7'b0, irq_n}, 8'h01);

    wr(8'h0E, 8'h01);
    pin_in = pin_in ^ 8'h04; v1 = pin_in; idle(4);
    check("R9 irq raised", {7'b0, irq_n}, 8'h00);
    pin_in = pin_in ^ 8'h08; idle(4);
    rd(8'h0B, v1, "R9 held snapshot");
    rd(8'h0B, pin_in, "R9 live after read");
    check("R9 irq cleared", {7'b0, irq_n}, 8'h01);

    wr(8'h0A, 8'h0F);
    wr(8'h0C, 8'hFF);
    pin_in = pin_in ^ 8'h80; idle(4);
    check("R7 irq pending before srst", {7'b0, irq_n}, 8'h00);
    wr(8'h0E, 8'h08);
    check("R7 request bit one cycle", pin_oe, 8'h0F);
    idle(1);
    check("R7 oe cleared", pin_oe, 8'h00);
    check("R7 irq released", {7'b0, irq_n}, 8'h01);
    rd(8'h0C, 8'h00, "R7 enable cleared");
    rd(8'h0E, 8'h00, "R7 control cleared");
    rd(8'h0A, 8'h00, "R7 dir cleared");
    idle(2);
    check("R10 queue drained", 8'(exp_q.size()), 8'h00);
    check("R11 out low at end", pin_out, 8'h00);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule